// File: doc/BRIEF.md
# Sequential Signed-Magnitude Multiplier

This block multiplies two signed-magnitude operands by the shift-and-add method and handles one multiplier bit per clock. The multiplicand magnitude is held in a register `b_q`. The multiplier magnitude is held in `q_q`, which also collects the low half of the result. A partial-product register `a_q` holds the upper half, and one extra bit holds the adder carry. On every step the block adds the multiplicand into the partial product if the rightmost multiplier bit is 1. It then shifts the carry, partial product and multiplier right as one word, with a 0 entering at the top. A down-counter that starts at the operand width counts the steps and ends the operation when it reaches zero.

The sign of the result is computed once, at start, as the exclusive-OR of the two operand signs. The magnitudes never pass through a two's-complement form. A caller pulses `start` with both operands present and waits for the one-cycle `done` pulse. The 2W-bit product magnitude and its sign then stay on the outputs until the next accepted start.

Top module: `smag_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0, `prod_mag` is all zeros and `prod_sgn` is 0.
- R2: A `start` sampled high while `busy` is 0 captures both magnitudes and signs, and `busy` is 1 in the cycle after that edge.
- R3: Each step adds the multiplicand to the partial product only when the inspected multiplier bit is 1, so `prod_mag` at completion equals the unsigned product of the two magnitudes (upper half from the partial-product register, lower half from the multiplier register).
- R4: `prod_sgn` equals `mcand_sgn` XOR `mplier_sgn` of the accepted operands, also when either magnitude is zero.
- R5: `done` is 1 for exactly one cycle: the cycle after the W-th rising edge that follows the edge that sampled `start`. `busy` falls at that same edge.
- R6: `start` is ignored while `busy` is 1. Neither the result nor the completion time changes.
- R7: `prod_mag` and `prod_sgn` hold their values from completion until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand_mag | input | W | Multiplicand magnitude |
| mcand_sgn | input | 1 | Multiplicand sign, 1 = negative |
| mplier_mag | input | W | Multiplier magnitude |
| mplier_sgn | input | 1 | Multiplier sign, 1 = negative |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_mag | output | 2W | Product magnitude |
| prod_sgn | output | 1 | Product sign |

## Verification
Inputs change at falling edges. If the edge that samples `start` is called edge 0, `busy` is due at the falling edge after edge 0 and `done` at the falling edge after edge W. The bench counts falling edges from the start pulse and requires `done` to be low at the first W of them, high at falling edge W+1 and low again at W+2. It compares the product and sign at the falling edge where `done` is high, and compares them again a few cycles later to check that they hold. In the ignored-start scenario the same edge count must still hold, which shows that the second pulse did not restart the counter.

// File: rtl/smag_seq_mult.sv
module smag_seq_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand_mag,
  input  logic           mcand_sgn,
  input  logic [W-1:0]   mplier_mag,
  input  logic           mplier_sgn,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] prod_mag,
  output logic           prod_sgn
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(W);

  logic [W-1:0]  b_q, a_q, q_q;
  logic [CW-1:0] cnt_q;
  logic          sgn_q, busy_q, done_q;
  logic [W:0]    ea_sum;

  // carry plus partial product, before the shift
  assign ea_sum = q_q[0] ? ({1'b0, a_q} + {1'b0, b_q}) : {1'b0, a_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q    <= '0;
      a_q    <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      sgn_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          b_q    <= mcand_mag;
          q_q    <= mplier_mag;
          a_q    <= '0;
          sgn_q  <= mcand_sgn ^ mplier_sgn;
          cnt_q  <= CNT_INIT;
          busy_q <= 1'b1;
        end
      end else begin
        a_q   <= ea_sum[W:1];
        q_q   <= {ea_sum[0], q_q[W-1:1]};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign prod_mag = {a_q, q_q};
  assign prod_sgn = sgn_q;

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r5_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0 && cnt_q <= CNT_INIT));
  a_r6_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(b_q) && $stable(prod_sgn));
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(prod_mag) && $stable(prod_sgn));
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

// File: tb/smag_seq_mult_tb.sv
module smag_seq_mult_tb_top;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] mcand_mag = '0, mplier_mag = '0;
  logic mcand_sgn = 1'b0, mplier_sgn = 1'b0;
  logic busy, done, prod_sgn;
  logic [2*W-1:0] prod_mag;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  smag_seq_mult #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand_mag(mcand_mag), .mcand_sgn(mcand_sgn),
    .mplier_mag(mplier_mag), .mplier_sgn(mplier_sgn),
    .busy(busy), .done(done), .prod_mag(prod_mag), .prod_sgn(prod_sgn));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 prod_mag", prod_mag, 0);
    chk("R1 prod_sgn", prod_sgn, 0);
  endtask

  // run one multiplication; if poke, pulse start with other operands mid-run (R6)
  task automatic t_mul(logic [W-1:0] a, logic as, logic [W-1:0] b, logic bs, bit poke);
    logic [2*W-1:0] exp_m = (2*W)'(a) * (2*W)'(b);
    logic exp_s = as ^ bs;
    @(negedge clk);
    mcand_mag = a; mcand_sgn = as; mplier_mag = b; mplier_sgn = bs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", busy, 1);
    for (int i = 1; i <= W; i++) begin
      if (i > 1) @(negedge clk);
      if (poke && i == 3) begin
        mcand_mag = ~a; mplier_mag = ~b; mcand_sgn = ~as; start = 1'b1;
      end else start = 1'b0;
      if (done) chk("R5 early done", done, 0);
    end
    @(negedge clk);
    start = 1'b0;
    chk("R5 done due", done, 1);
    chk("R5 busy fallen", busy, 0);
    chk(poke ? "R6 R3 product" : "R3 product", prod_mag, exp_m);
    chk(poke ? "R6 R4 sign" : "R4 sign", prod_sgn, exp_s);
    @(negedge clk);
    chk("R5 done single", done, 0);
    repeat (3) @(negedge clk);
    chk("R7 mag held", prod_mag, exp_m);
    chk("R7 sgn held", prod_sgn, exp_s);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mul(8'd13, 1'b0, 8'd11, 1'b0, 0);
    t_mul(8'hFF, 1'b1, 8'hFF, 1'b0, 0);
    t_mul(8'd0, 1'b1, 8'd57, 1'b0, 0);   // R4 zero magnitude still XOR
    t_mul(8'd1, 1'b1, 8'd1, 1'b1, 0);
    t_mul(8'hA5, 1'b0, 8'h80, 1'b1, 0);
    t_mul(8'd200, 1'b1, 8'd3, 1'b0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #40000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule